// File: doc/BRIEF.md
# Cache-Watch Register Window

This block gives software a narrow view onto one entry of a wide table. Software selects an entry through a 64-bit selector register. The selector holds a block identifier and an entry offset. The entry's words then appear in a bank of NWORDS 64-bit data registers.

Data word 0 is the trigger for a transfer. A read of word 0 fetches the whole entry from the table. A write of word 0 stores the written value and then pushes all NWORDS staging registers back to the table as one entry. The remaining data words are plain staging latches and never start a transfer.

The table side is one request channel with a valid/ready handshake. The table holds its words big-endian, and the block byte-swaps every 64-bit word on its way in and out. A fetch that the table marks invalid loads zeros, raises a one-cycle error pulse, and sets a sticky status bit. Two scrub registers accept writes and do nothing. The same module serves a 4-word table and an 8-word table; only the NWORDS parameter differs.

Top module: `cwatch_window`

## Requirements
- R1: The selector register (word address 0) holds the entry offset in bits [OFF_W-1:0] and the block identifier in bits [32+BLK_W-1:32]. Every table request carries these two fields on `tbl_idx` and `tbl_blk`.
- R2: Any write to the selector clears its conflict bit (bit 63), whatever value is written. A read of the selector returns the stored value with both the conflict bit (63) and the full bit (62) forced to zero.
- R3: A write to data word 0 (address DATA_BASE) first latches the written value. It then issues one table write (`tbl_we`=1) carrying all NWORDS registers, byte-swapped, with register i placed at `tbl_wdata[64*i +: 64]`.
- R4: A read of data word 0 issues one table read (`tbl_we`=0). It loads every data register i with the byte-swapped `tbl_rdata[64*i +: 64]` and returns the freshly loaded word 0.
- R5: Reads and writes of data words 1 to NWORDS-1 (addresses DATA_BASE+1 onward) only access the latched value and never assert `tbl_valid`.
- R6: If the table completes a read with `tbl_err` high, every data register is loaded with zero. In that case `err_pulse` is high for exactly the following cycle.
- R7: The status register (address 1) shows a sticky error flag in bit 0. An invalid fetch sets it. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R8: The scrub mask (address 2) and scrub trigger (address 3) registers accept writes with no side effect. They read as zero and start no table transfer.
- R9: `reg_ready` stays low from the first cycle of a word-0 access until the table handshake completes. It is high in the single cycle after that handshake. `tbl_valid` and its request fields stay stable until `tbl_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Register word address |
| reg_rd | input | 1 | Read strobe, held until `reg_ready` |
| reg_wr | input | 1 | Write strobe, held until `reg_ready` |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid when `reg_ready` is high |
| reg_ready | output | 1 | Access completes at the clock edge while high |
| tbl_valid | output | 1 | Table request valid |
| tbl_we | output | 1 | 1 = entry write, 0 = entry read |
| tbl_blk | output | BLK_W | Block identifier of the request |
| tbl_idx | output | OFF_W | Entry offset of the request |
| tbl_wdata | output | 64*NWORDS | Entry to write, big-endian words |
| tbl_ready | input | 1 | Table accepts and completes the request this cycle |
| tbl_rdata | input | 64*NWORDS | Entry read, valid with `tbl_ready` |
| tbl_err | input | 1 | Entry invalid, valid with `tbl_ready` on reads |
| err_pulse | output | 1 | One-cycle invalid-fetch flag |

## Verification
Every register access other than word 0 completes in the cycle it is presented. A word-0 access turns `reg_ready` on two cycles after presentation plus the table's added latency. The bench's responder can be programmed with that latency, and the bench counts the not-ready samples against this figure. `err_pulse` is due in the cycle after the handshake that reported the invalid entry. The bench compares it every clock against a flag its own table model sets at that handshake. On the same clock, the bench flags any `tbl_valid` seen outside a word-0 access. Table contents written back are read from the bench's model memory once the write access has completed.

// File: rtl/cwatch_window.sv
module cwatch_window #(
  parameter int NWORDS    = 4,
  parameter int BLK_W     = 4,
  parameter int OFF_W     = 16,
  parameter int AW        = 4,
  parameter int DATA_BASE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [63:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  output logic                 reg_ready,
  output logic                 tbl_valid,
  output logic                 tbl_we,
  output logic [BLK_W-1:0]     tbl_blk,
  output logic [OFF_W-1:0]     tbl_idx,
  output logic [64*NWORDS-1:0] tbl_wdata,
  input  logic                 tbl_ready,
  input  logic [64*NWORDS-1:0] tbl_rdata,
  input  logic                 tbl_err,
  output logic                 err_pulse
);
  localparam logic [AW-1:0] A_SEL   = AW'(0);
  localparam logic [AW-1:0] A_STAT  = AW'(1);
  localparam logic [AW-1:0] A_SMASK = AW'(2);
  localparam logic [AW-1:0] A_STRIG = AW'(3);
  localparam logic [AW-1:0] A_D0    = AW'(DATA_BASE);
  localparam int            DW      = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;

  state_t      st;
  logic        we_q;
  logic        err_sticky;
  logic [63:0] sel_q;
  logic [63:0] data_q [NWORDS];

  function automatic logic [63:0] bswap(input logic [63:0] x);
    for (int b = 0; b < 8; b++) bswap[8*b +: 8] = x[8*(7-b) +: 8];
  endfunction

  logic          access, is_d0, is_data, done_hs;
  logic [AW-1:0] doff;
  logic [DW-1:0] dsel;

  assign access  = reg_rd | reg_wr;
  assign is_d0   = reg_addr == A_D0;
  assign doff    = reg_addr - A_D0;
  assign is_data = (reg_addr >= A_D0) && (int'(doff) < NWORDS);
  assign dsel    = DW'(doff);
  assign done_hs = tbl_valid & tbl_ready;

  assign reg_ready = (st == S_DONE) || !(access && is_d0);
  assign tbl_valid = st == S_BUSY;
  assign tbl_we    = we_q;
  assign tbl_blk   = sel_q[32 +: BLK_W];
  assign tbl_idx   = sel_q[0 +: OFF_W];

  for (genvar i = 0; i < NWORDS; i++) begin : g_wd
    assign tbl_wdata[64*i +: 64] = bswap(data_q[i]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SEL)       reg_rdata = sel_q & ~(64'h3 << 62);
    else if (reg_addr == A_STAT) reg_rdata = {63'd0, err_sticky};
    else if (is_data)            reg_rdata = data_q[dsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      we_q       <= 1'b0;
      err_sticky <= 1'b0;
      err_pulse  <= 1'b0;
      sel_q      <= '0;
      for (int i = 0; i < NWORDS; i++) data_q[i] <= '0;
    end else begin
      err_pulse <= 1'b0;
      case (st)
        S_IDLE: if (access) begin
          if (reg_wr) begin
            if (reg_addr == A_SEL) sel_q <= reg_wdata & ~(64'h1 << 63);
            if (reg_addr == A_STAT && reg_wdata[0]) err_sticky <= 1'b0;
            if (is_data) data_q[dsel] <= reg_wdata;
          end
          if (is_d0) begin
            st   <= S_BUSY;
            we_q <= reg_wr;
          end
        end
        S_BUSY: if (done_hs) begin
          st <= S_DONE;
          if (!we_q) begin
            for (int i = 0; i < NWORDS; i++)
              data_q[i] <= tbl_err ? 64'd0 : bswap(tbl_rdata[64*i +: 64]);
            if (tbl_err) begin
              err_sticky <= 1'b1;
              err_pulse  <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid && !tbl_ready |=> tbl_valid && $stable(tbl_we) && $stable(tbl_idx) && $stable(tbl_blk));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid |-> !reg_ready);

  // R6
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(tbl_valid && tbl_ready && !tbl_we && tbl_err));

  // R7
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> err_pulse);

  // R5
  no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && access && !is_d0 |=> !tbl_valid);

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
endmodule

// File: tb/sim_cwatch_window.sv
module sim_cwatch_window;
  localparam int N  = 4;
  localparam int EW = 64 * N;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic          reg_rd = 1'b0, reg_wr = 1'b0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          reg_ready;
  logic          tbl_valid, tbl_we, err_pulse;
  logic [3:0]    tbl_blk;
  logic [15:0]   tbl_idx;
  logic [EW-1:0] tbl_wdata;
  logic          tbl_ready = 1'b0;
  logic [EW-1:0] tbl_rdata = '0;
  logic          tbl_err = 1'b0;

  cwatch_window #(.NWORDS(N), .BLK_W(4), .OFF_W(16), .AW(4), .DATA_BASE(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .tbl_valid(tbl_valid), .tbl_we(tbl_we), .tbl_blk(tbl_blk), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .tbl_ready(tbl_ready), .tbl_rdata(tbl_rdata),
    .tbl_err(tbl_err), .err_pulse(err_pulse));

  int checks = 0, errors = 0;
  logic [EW-1:0] mem [16];
  int delay = 0, cnt = 0;
  logic xfer_ok = 1'b0, exp_err = 1'b0, pend_err;
  logic [3:0] cap_blk;
  logic [15:0] cap_idx;
  logic cap_we;

  function automatic logic [63:0] sw(input logic [63:0] x);
    sw = {<<8{x}};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 err_pulse per cycle", {63'd0, err_pulse}, {63'd0, exp_err});
      if (tbl_valid && !xfer_ok) chk("R5 R8 unexpected table request", 64'd1, 64'd0);
    end
    pend_err = 1'b0;
    if (tbl_ready) begin
      tbl_ready = 1'b0;
      tbl_err   = 1'b0;
    end else if (tbl_valid) begin
      if (cnt == delay) begin
        cnt = 0;
        tbl_ready = 1'b1;
        cap_blk = tbl_blk; cap_idx = tbl_idx; cap_we = tbl_we;
        if (tbl_we) mem[tbl_idx[3:0]] = tbl_wdata;
        else begin
          tbl_rdata = mem[tbl_idx[3:0]];
          tbl_err   = tbl_idx >= 16'd12;
          pend_err  = tbl_err;
        end
      end else cnt++;
    end
    exp_err = pend_err;
  end

  task automatic bus(input bit wr, input logic [3:0] a, input logic [63:0] d,
                     output logic [63:0] rd, output int stalls);
    reg_addr = a; reg_wr = wr; reg_rd = !wr; reg_wdata = d; stalls = 0;
    #1;
    while (!reg_ready && stalls < 1000) begin
      @(negedge clk); #1;
      stalls++;
    end
    rd = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r, x1, x2, z, w3;
    int st;
    for (int i = 0; i < 16; i++)
      for (int w = 0; w < N; w++)
        mem[i][64*w +: 64] = 64'h0102_0304_0506_0708 * 64'(i + 1) + 64'(w);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    bus(0, 4'd1, 0, r, st); chk("R7 reset status", r, 0);
    bus(0, 4'd9, 0, r, st); chk("R5 reset data1", r, 0);
    bus(0, 4'd0, 0, r, st); chk("R2 reset selector", r, 0);

    bus(1, 4'd0, '1, r, st);
    bus(0, 4'd0, 0, r, st); chk("R2 selector status bits clear", r, 64'h3FFF_FFFF_FFFF_FFFF);

    bus(1, 4'd0, (64'd5 << 32) | 64'd3, r, st);
    delay = 2; xfer_ok = 1'b1;
    bus(0, 4'd8, 0, r, st);
    xfer_ok = 1'b0;
    chk("R4 word0 fetched", r, sw(mem[3][63:0]));
    chk("R9 read stall cycles", 64'(st), 64'd4);
    chk("R1 block id", {60'd0, cap_blk}, 64'd5);
    chk("R1 offset", {48'd0, cap_idx}, 64'd3);
    chk("R4 request is read", {63'd0, cap_we}, 0);
    for (int w = 1; w < N; w++) begin
      bus(0, 4'(8 + w), 0, r, st); chk("R4 word loaded", r, sw(mem[3][64*w +: 64]));
    end

    x1 = 64'hA1A2_A3A4_A5A6_A7A8; x2 = 64'hB1B2_B3B4_B5B6_B7B8;
    bus(1, 4'd9, x1, r, st);
    bus(1, 4'd10, x2, r, st);
    bus(0, 4'd9, 0, r, st); chk("R5 data1 latch", r, x1);
    bus(0, 4'd10, 0, r, st); chk("R5 data2 latch", r, x2);

    w3 = mem[3][192 +: 64];
    z = 64'hC0C1_C2C3_C4C5_C6C7;
    delay = 0; xfer_ok = 1'b1;
    bus(1, 4'd8, z, r, st);
    xfer_ok = 1'b0;
    chk("R9 write stall cycles", 64'(st), 64'd2);
    chk("R3 request is write", {63'd0, cap_we}, 1);
    chk("R3 word0 stored", mem[3][63:0], sw(z));
    chk("R3 word1 stored", mem[3][127:64], sw(x1));
    chk("R3 word2 stored", mem[3][191:128], sw(x2));
    chk("R3 word3 stored", mem[3][255:192], w3);
    xfer_ok = 1'b1;
    bus(0, 4'd8, 0, r, st);
    xfer_ok = 1'b0;
    chk("R4 round trip word0", r, z);

    bus(1, 4'd0, (64'd2 << 32) | 64'd13, r, st);
    delay = 1; xfer_ok = 1'b1;
    bus(0, 4'd8, 0, r, st);
    xfer_ok = 1'b0;
    chk("R6 invalid word0 zero", r, 0);
    bus(0, 4'd9, 0, r, st); chk("R6 invalid data1 zero", r, 0);
    bus(0, 4'd1, 0, r, st); chk("R7 sticky set", r, 1);

    bus(1, 4'd1, 0, r, st);
    bus(0, 4'd1, 0, r, st); chk("R7 write 0 keeps", r, 1);
    bus(1, 4'd1, 1, r, st);
    bus(0, 4'd1, 0, r, st); chk("R7 write 1 clears", r, 0);

    bus(1, 4'd9, x2, r, st);
    bus(1, 4'd2, '1, r, st);
    bus(1, 4'd3, '1, r, st);
    bus(0, 4'd2, 0, r, st); chk("R8 scrub mask reads 0", r, 0);
    bus(0, 4'd3, 0, r, st); chk("R8 scrub trigger reads 0", r, 0);
    bus(0, 4'd9, 0, r, st); chk("R8 data1 untouched", r, x2);
    bus(0, 4'd0, 0, r, st); chk("R8 selector untouched", r, (64'd2 << 32) | 64'd13);
    bus(0, 4'd1, 0, r, st); chk("R8 status untouched", r, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule